// File: doc/BRIEF.md
# Slot-Owned DRAM Command Sequencer with Periodic Refresh

This block turns a stream of memory requests from several requestors into a stream of DRAM commands, one command every clock cycle. Time is cut into a repeating frame of `NUM_SLOTS` slots, each `SLOT_LEN` cycles long. Slot *k* belongs to requestor *k*. At the first cycle of a slot, the oldest waiting request of that slot's owner is taken from a shared queue. It is then served with a precharge, an activate and a column command, each at a fixed cycle offset inside the slot. Because every request gets the same fixed slot of time, the latency seen by one requestor is bounded no matter what the other requestors do.

Refresh is woven into the same command stream. A refresh timer counts up to a deadline derived from the refresh interval. Service may only start while a whole frame still fits before that deadline. At the deadline the block issues a precharge-all, then a refresh, and waits out the refresh recovery time before it serves again. The slot and cycle counters keep running through refresh, so slot ownership never drifts.

Each cycle the registered outputs carry one command code and the request fields that go with it: requestor, read or write, bank group, bank, row and column.

Top module: `tdm_cmd_sched`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `cmd_o` is 0 (NOP) and every request output field is 0.
- R2: A cycle counter runs 0..SLOT_LEN-1 and wraps. A slot counter runs 0..NUM_SLOTS-1 and advances only when the cycle counter wraps. Both counters advance every cycle in every mode, and a request of requestor k is only started in slot k.
- R3: From idle, a service starts only at slot cycle 0, and only when refresh count + NUM_SLOTS*SLOT_LEN < T_REFI-T_RP. Otherwise the block emits NOP.
- R4: On a start, the oldest queued request whose requestor field equals the current slot is removed from the queue and PRE (code 1) is output with its fields. If no such request exists, the block stays idle and emits NOP.
- R5: During a service, ACT (code 2) is output with the request fields at slot cycle T_RP.
- R6: During a service, the column command is output at slot cycle T_RP+T_RCD: RD (code 3) when the write flag is 0, WR (code 4) when it is 1.
- R7: Every other service cycle outputs NOP carrying the request fields. At slot cycle SLOT_LEN-1 the block outputs NOP with zero fields and goes idle.
- R8: From idle, when the refresh count equals T_REFI-T_RP-1, the block outputs PREA (code 5) with zero fields, clears the refresh count and enters refresh.
- R9: In refresh, REF (code 6) is output at refresh count T_RP-1. At count T_RP-1+T_RFC the block goes idle and clears the refresh count. All refresh-mode outputs carry zero fields.
- R10: An arrival (`arr_valid` high) is appended at the tail of the queue in every mode. It becomes eligible from the next cycle on, after all older entries.
- R11: Every NOP emitted in idle or refresh carries zero request fields.
- R12: The queue holds `Q_DEPTH` entries. An arrival is dropped when the queue is full, unless an entry is removed in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arr_valid | input | 1 | A new request is present this cycle |
| arr_id | input | clog2(NUM_SLOTS) | Requestor that owns the new request |
| arr_write | input | 1 | 1 = write, 0 = read |
| arr_bg | input | BG_W | Bank group of the new request |
| arr_bank | input | BA_W | Bank of the new request |
| arr_row | input | ROW_W | Row address of the new request |
| arr_col | input | COL_W | Column address of the new request |
| cmd_o | output | 3 | Command: 0 NOP, 1 PRE, 2 ACT, 3 RD, 4 WR, 5 PREA, 6 REF |
| out_id | output | clog2(NUM_SLOTS) | Requestor of the command's request |
| out_write | output | 1 | Write flag of the command's request |
| out_bg | output | BG_W | Bank group of the command's request |
| out_bank | output | BA_W | Bank of the command's request |
| out_row | output | ROW_W | Row of the command's request |
| out_col | output | COL_W | Column of the command's request |

## Verification
The bench first runs with no traffic at all. This isolates the refresh cadence, so a wrong deadline or wrong recovery length shows up on its own. Next comes a stream from one requestor only, which shows whether service waits for the owner's slot and keeps arrival order. Random traffic from all requestors follows; it mixes reads and writes and lands near the refresh window, which tells apart the owner-gated selection, the start-window test and the command offsets. Last, a flood that arrives every cycle fills the queue and checks the drop rule, including arrivals in the same cycle as a removal. A cycle-accurate arithmetic model compares every output in every cycle.

// File: rtl/tdm_sched_pkg.sv
package tdm_sched_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PRE  = 3'd1,
    CMD_ACT  = 3'd2,
    CMD_RD   = 3'd3,
    CMD_WR   = 3'd4,
    CMD_PREA = 3'd5,
    CMD_REF  = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    MODE_IDLE    = 2'd0,
    MODE_SERVE   = 2'd1,
    MODE_REFRESH = 2'd2
  } mode_e;

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int SLOT_LEN  = 8,
  parameter int NUM_SLOTS = 3,
  parameter int CYC_W     = $clog2(SLOT_LEN),
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [CYC_W-1:0]  cyc_o,
  output logic [SLOT_W-1:0] slot_o
);

  localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(SLOT_LEN - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

  logic [CYC_W-1:0]  cyc_q;
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q  <= '0;
      slot_q <= '0;
    end else if (cyc_q == CYC_LAST) begin
      cyc_q  <= '0;
      slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
    end else begin
      cyc_q  <= cyc_q + 1'b1;
    end
  end

  assign cyc_o  = cyc_q;
  assign slot_o = slot_q;

endmodule

// File: rtl/tdm_req_queue.sv
module tdm_req_queue #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 24,
  parameter int ID_W   = 2,
  parameter int ID_LSB = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [ID_W-1:0]   sel_id_i,
  input  logic              pop_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] hit_data_o
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q     [DEPTH];
  logic [DATA_W-1:0] shift_src [DEPTH];
  logic [CNT_W-1:0]  count_q;
  logic [IDX_W-1:0]  hit_idx;
  logic              hit;
  logic              do_pop;
  logic              accept;
  logic [CNT_W-1:0]  wr_pos;

  // head-to-tail priority search: lowest matching index wins
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if ((CNT_W'(i) < count_q) && (mem_q[i][ID_LSB +: ID_W] == sel_id_i)) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  assign hit_o      = hit;
  assign hit_data_o = mem_q[hit_idx];

  // source of each entry when the entries above a removed one slide down
  for (genvar g = 0; g < DEPTH; g++) begin : g_src
    if (g == DEPTH - 1) begin : g_top
      assign shift_src[g] = mem_q[g];
    end else begin : g_mid
      assign shift_src[g] = mem_q[g+1];
    end
  end

  assign do_pop = pop_i & hit;
  assign accept = push_i & ((count_q != CNT_W'(DEPTH)) | do_pop);
  assign wr_pos = do_pop ? count_q - 1'b1 : count_q;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (accept && (wr_pos == CNT_W'(i))) begin
        mem_q[i] <= push_data_i;
      end else if (do_pop && (IDX_W'(i) >= hit_idx)) begin
        mem_q[i] <= shift_src[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else begin
      count_q <= count_q - CNT_W'(do_pop) + CNT_W'(accept);
    end
  end

endmodule

// File: rtl/tdm_cmd_ctrl.sv
module tdm_cmd_ctrl
  import tdm_sched_pkg::*;
#(
  parameter int SLOT_LEN  = 8,
  parameter int NUM_SLOTS = 3,
  parameter int T_RP      = 2,
  parameter int T_RCD     = 2,
  parameter int T_RFC     = 6,
  parameter int T_REFI    = 66,
  parameter int DATA_W    = 24,
  parameter int KIND_BIT  = 21,
  parameter int CYC_W     = $clog2(SLOT_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CYC_W-1:0]  cyc_i,
  input  logic              q_hit_i,
  input  logic [DATA_W-1:0] q_data_i,
  output logic              pop_o,
  output logic [2:0]        cmd_o,
  output logic [DATA_W-1:0] req_o
);

  localparam int PREA_DATE = T_REFI - T_RP;
  localparam int PERIOD    = NUM_SLOTS * SLOT_LEN;
  localparam int REF_AT    = T_RP - 1;
  localparam int END_AT    = REF_AT + T_RFC;
  localparam int CREF_W    = $clog2(PREA_DATE);

  localparam logic [CYC_W-1:0]  ACT_CYC  = CYC_W'(T_RP);
  localparam logic [CYC_W-1:0]  CAS_CYC  = CYC_W'(T_RP + T_RCD);
  localparam logic [CYC_W-1:0]  LAST_CYC = CYC_W'(SLOT_LEN - 1);
  localparam logic [CREF_W-1:0] CREF_TOP = CREF_W'(PREA_DATE - 1);
  localparam logic [CREF_W-1:0] CREF_REF = CREF_W'(REF_AT);
  localparam logic [CREF_W-1:0] CREF_END = CREF_W'(END_AT);

  mode_e              mode_q, mode_d;
  logic [CREF_W-1:0]  cref_q, cref_d;
  logic [DATA_W-1:0]  cur_q, cur_d;
  cmd_e               cmd_q, cmd_d;
  logic [DATA_W-1:0]  req_q, req_d;
  logic               pop;
  logic               window_ok;

  assign window_ok = (int'(cref_q) + PERIOD) < PREA_DATE;

  always_comb begin
    mode_d = mode_q;
    cref_d = (cref_q == CREF_TOP) ? '0 : cref_q + 1'b1;
    cur_d  = cur_q;
    cmd_d  = CMD_NOP;
    req_d  = '0;
    pop    = 1'b0;
    case (mode_q)
      MODE_IDLE: begin
        if (window_ok) begin
          if ((cyc_i == '0) && q_hit_i) begin
            pop    = 1'b1;
            cur_d  = q_data_i;
            cmd_d  = CMD_PRE;
            req_d  = q_data_i;
            mode_d = MODE_SERVE;
          end
        end else if (cref_q == CREF_TOP) begin
          cmd_d  = CMD_PREA;
          cref_d = '0;
          mode_d = MODE_REFRESH;
        end
      end
      MODE_SERVE: begin
        if (cyc_i == ACT_CYC) begin
          cmd_d = CMD_ACT;
          req_d = cur_q;
        end else if (cyc_i == CAS_CYC) begin
          cmd_d = cur_q[KIND_BIT] ? CMD_WR : CMD_RD;
          req_d = cur_q;
        end else if (cyc_i == LAST_CYC) begin
          mode_d = MODE_IDLE;
        end else begin
          req_d = cur_q;
        end
      end
      MODE_REFRESH: begin
        if (cref_q == CREF_REF) begin
          cmd_d = CMD_REF;
        end else if (cref_q == CREF_END) begin
          mode_d = MODE_IDLE;
          cref_d = '0;
        end
      end
      default: mode_d = MODE_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_IDLE;
      cref_q <= '0;
      cur_q  <= '0;
      cmd_q  <= CMD_NOP;
      req_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cref_q <= cref_d;
      cur_q  <= cur_d;
      cmd_q  <= cmd_d;
      req_q  <= req_d;
    end
  end

  assign pop_o = pop;
  assign cmd_o = cmd_q;
  assign req_o = req_q;

endmodule

// File: rtl/tdm_cmd_sched.sv
module tdm_cmd_sched #(
  parameter int SLOT_LEN  = 8,
  parameter int NUM_SLOTS = 3,
  parameter int T_RP      = 2,
  parameter int T_RCD     = 2,
  parameter int T_RFC     = 6,
  parameter int T_REFI    = 66,
  parameter int Q_DEPTH   = 4,
  parameter int BG_W      = 2,
  parameter int BA_W      = 2,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         arr_valid,
  input  logic [$clog2(NUM_SLOTS)-1:0] arr_id,
  input  logic                         arr_write,
  input  logic [BG_W-1:0]              arr_bg,
  input  logic [BA_W-1:0]              arr_bank,
  input  logic [ROW_W-1:0]             arr_row,
  input  logic [COL_W-1:0]             arr_col,
  output logic [2:0]                   cmd_o,
  output logic [$clog2(NUM_SLOTS)-1:0] out_id,
  output logic                         out_write,
  output logic [BG_W-1:0]              out_bg,
  output logic [BA_W-1:0]              out_bank,
  output logic [ROW_W-1:0]             out_row,
  output logic [COL_W-1:0]             out_col
);

  localparam int ID_W     = $clog2(NUM_SLOTS);
  localparam int CYC_W    = $clog2(SLOT_LEN);
  localparam int REQ_W    = ID_W + 1 + BG_W + BA_W + ROW_W + COL_W;
  localparam int ID_LSB   = REQ_W - ID_W;
  localparam int KIND_BIT = ID_LSB - 1;

  logic [CYC_W-1:0] cyc_w;
  logic [ID_W-1:0]  slot_w;
  logic [REQ_W-1:0] arr_pack;
  logic [REQ_W-1:0] hit_data;
  logic [REQ_W-1:0] req_out;
  logic             hit;
  logic             pop;

  assign arr_pack = {arr_id, arr_write, arr_bg, arr_bank, arr_row, arr_col};

  tdm_slot_timer #(
    .SLOT_LEN (SLOT_LEN),
    .NUM_SLOTS(NUM_SLOTS),
    .CYC_W    (CYC_W),
    .SLOT_W   (ID_W)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .cyc_o (cyc_w),
    .slot_o(slot_w)
  );

  tdm_req_queue #(
    .DEPTH (Q_DEPTH),
    .DATA_W(REQ_W),
    .ID_W  (ID_W),
    .ID_LSB(ID_LSB)
  ) u_queue (
    .clk        (clk),
    .rst        (rst),
    .push_i     (arr_valid),
    .push_data_i(arr_pack),
    .sel_id_i   (slot_w),
    .pop_i      (pop),
    .hit_o      (hit),
    .hit_data_o (hit_data)
  );

  tdm_cmd_ctrl #(
    .SLOT_LEN (SLOT_LEN),
    .NUM_SLOTS(NUM_SLOTS),
    .T_RP     (T_RP),
    .T_RCD    (T_RCD),
    .T_RFC    (T_RFC),
    .T_REFI   (T_REFI),
    .DATA_W   (REQ_W),
    .KIND_BIT (KIND_BIT),
    .CYC_W    (CYC_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cyc_i   (cyc_w),
    .q_hit_i (hit),
    .q_data_i(hit_data),
    .pop_o   (pop),
    .cmd_o   (cmd_o),
    .req_o   (req_out)
  );

  assign {out_id, out_write, out_bg, out_bank, out_row, out_col} = req_out;

endmodule

// File: rtl/tdm_cmd_sched_chk.sv
module tdm_cmd_sched_chk
  import tdm_sched_pkg::*;
#(
  parameter int SLOT_LEN = 8,
  parameter int T_RP     = 2,
  parameter int T_RCD    = 2,
  parameter int ID_W     = 2,
  parameter int CYC_W    = 3,
  parameter int BG_W     = 2,
  parameter int BA_W     = 2,
  parameter int ROW_W    = 8,
  parameter int COL_W    = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       cmd_o,
  input logic [ID_W-1:0]  out_id,
  input logic             out_write,
  input logic [BG_W-1:0]  out_bg,
  input logic [BA_W-1:0]  out_bank,
  input logic [ROW_W-1:0] out_row,
  input logic [COL_W-1:0] out_col,
  input logic [CYC_W-1:0] cyc_w,
  input logic [ID_W-1:0]  slot_w
);

  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(SLOT_LEN - 1);

  logic fields_zero;
  assign fields_zero = (out_id == '0) && !out_write && (out_bg == '0) &&
                       (out_bank == '0) && (out_row == '0) && (out_col == '0);

  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_w != LAST_CYC) |=> $stable(slot_w));

  // R4
  pre_at_slot_start_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_PRE) |-> (cyc_w == CYC_W'(1)) && (out_id == slot_w));

  // R5
  act_offset_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_ACT) |-> (cyc_w == CYC_W'(T_RP + 1)) && (out_id == slot_w));

  // R6
  col_offset_chk: assert property (@(posedge clk) disable iff (rst)
    ((cmd_o == CMD_RD) || (cmd_o == CMD_WR)) |->
      (cyc_w == CYC_W'(T_RP + T_RCD + 1)) && (out_write == (cmd_o == CMD_WR)));

  // R9
  refresh_fields_chk: assert property (@(posedge clk) disable iff (rst)
    ((cmd_o == CMD_PREA) || (cmd_o == CMD_REF)) |-> fields_zero);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (cmd_o == CMD_NOP) && fields_zero);

endmodule

bind tdm_cmd_sched tdm_cmd_sched_chk #(
  .SLOT_LEN(SLOT_LEN),
  .T_RP    (T_RP),
  .T_RCD   (T_RCD),
  .ID_W    ($clog2(NUM_SLOTS)),
  .CYC_W   ($clog2(SLOT_LEN)),
  .BG_W    (BG_W),
  .BA_W    (BA_W),
  .ROW_W   (ROW_W),
  .COL_W   (COL_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .cmd_o    (cmd_o),
  .out_id   (out_id),
  .out_write(out_write),
  .out_bg   (out_bg),
  .out_bank (out_bank),
  .out_row  (out_row),
  .out_col  (out_col),
  .cyc_w    (cyc_w),
  .slot_w   (slot_w)
);

// File: tb/tdm_cmd_sched_tb.sv
module tdm_cmd_sched_tb_top;

  localparam int SL     = 8;
  localparam int SN     = 3;
  localparam int TRP    = 2;
  localparam int TRCD   = 2;
  localparam int TRFC   = 6;
  localparam int TREFI  = 66;
  localparam int DEPTH  = 4;
  localparam int PREA   = TREFI - TRP;
  localparam int PERIOD = SN * SL;
  localparam int NCYC   = 3200;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       arr_valid = 1'b0;
  logic [1:0] arr_id = '0;
  logic       arr_write = 1'b0;
  logic [1:0] arr_bg = '0;
  logic [1:0] arr_bank = '0;
  logic [7:0] arr_row = '0;
  logic [5:0] arr_col = '0;
  logic [2:0] cmd_o;
  logic [1:0] out_id;
  logic       out_write;
  logic [1:0] out_bg;
  logic [1:0] out_bank;
  logic [7:0] out_row;
  logic [5:0] out_col;

  always #5 clk = ~clk;

  tdm_cmd_sched #(
    .SLOT_LEN(SL), .NUM_SLOTS(SN), .T_RP(TRP), .T_RCD(TRCD), .T_RFC(TRFC),
    .T_REFI(TREFI), .Q_DEPTH(DEPTH), .BG_W(2), .BA_W(2), .ROW_W(8), .COL_W(6)
  ) dut_i (
    .clk(clk), .rst(rst), .arr_valid(arr_valid), .arr_id(arr_id),
    .arr_write(arr_write), .arr_bg(arr_bg), .arr_bank(arr_bank),
    .arr_row(arr_row), .arr_col(arr_col), .cmd_o(cmd_o), .out_id(out_id),
    .out_write(out_write), .out_bg(out_bg), .out_bank(out_bank),
    .out_row(out_row), .out_col(out_col)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // request packed as {id[1:0], write, bg[1:0], bank[1:0], row[7:0], col[5:0]}
  logic [20:0] mq [DEPTH];
  int          m_cnt, m_mode, m_cyc, m_slot, m_cref;
  logic [20:0] m_cur;
  logic [2:0]  e_cmd;
  logic [20:0] e_req;
  string       e_tag;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  function automatic logic [31:0] step_lfsr(input logic [31:0] v);
    logic [31:0] x;
    x = v ^ (v << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual cmd=%0d req=%h expected cmd=%0d req=%h",
               tag, act[23:21], act[20:0], exp[23:21], exp[20:0]);
    end
  endtask

  // one cycle of the requirement-level model, from pre-edge state and inputs
  task automatic model_step(input bit v, input logic [20:0] areq);
    int  mode_n, cref_n;
    bit  popped;
    int  k;
    popped = 0;
    e_cmd  = 3'd0;
    e_req  = '0;
    mode_n = m_mode;
    cref_n = (m_cref == PREA - 1) ? 0 : m_cref + 1;
    if (m_mode == 0) begin
      e_tag = "R3/R11";
      if (m_cref + PERIOD < PREA) begin
        if (m_cyc == 0) begin
          k = -1;
          for (int i = m_cnt - 1; i >= 0; i--)
            if (int'(mq[i][20:19]) == m_slot) k = i;
          if (k >= 0) begin
            m_cur = mq[k];
            for (int i = k; i < DEPTH - 1; i++) mq[i] = mq[i+1];
            m_cnt--;
            popped = 1;
            e_cmd  = 3'd1;
            e_req  = m_cur;
            mode_n = 1;
            e_tag  = "R2/R4/R10";
          end
        end
      end else if (m_cref == PREA - 1) begin
        e_cmd  = 3'd5;
        cref_n = 0;
        mode_n = 2;
        e_tag  = "R8";
      end
    end else if (m_mode == 1) begin
      if (m_cyc == TRP) begin
        e_cmd = 3'd2; e_req = m_cur; e_tag = "R5";
      end else if (m_cyc == TRP + TRCD) begin
        e_cmd = m_cur[18] ? 3'd4 : 3'd3; e_req = m_cur; e_tag = "R6";
      end else if (m_cyc == SL - 1) begin
        mode_n = 0; e_tag = "R7";
      end else begin
        e_req = m_cur; e_tag = "R7";
      end
    end else begin
      e_tag = "R9/R11";
      if (m_cref == TRP - 1) begin
        e_cmd = 3'd6; e_tag = "R9";
      end else if (m_cref == TRP - 1 + TRFC) begin
        mode_n = 0; cref_n = 0;
      end
    end
    if (v && m_cnt < DEPTH) begin
      mq[m_cnt] = areq;
      m_cnt++;
    end
    if (popped && v) e_tag = {e_tag, "/R12"};
    m_mode = mode_n;
    m_cref = cref_n;
    if (m_cyc == SL - 1) begin
      m_cyc  = 0;
      m_slot = (m_slot == SN - 1) ? 0 : m_slot + 1;
    end else begin
      m_cyc++;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet under reset
    check("R1", {cmd_o, out_id, out_write, out_bg, out_bank, out_row, out_col}, 24'd0);
    m_cnt = 0; m_mode = 0; m_cyc = 0; m_slot = 0; m_cref = 0; m_cur = '0;
    rst = 1'b0;
    for (int t = 0; t < NCYC; t++) begin
      bit          v;
      logic [20:0] r;
      if (t > 0) begin
        string tag;
        tag = (t >= 2000 && t < 2600) ? {e_tag, " R12"} : e_tag;
        if (t == 1) tag = {tag, " R1"};
        check(tag, {cmd_o, out_id, out_write, out_bg, out_bank, out_row, out_col},
              {e_cmd, e_req});
      end
      lfsr = step_lfsr(lfsr);
      v = 1'b0;
      r = {2'(lfsr[9:0] % SN), lfsr[18:0]};
      if (t >= 200 && t < 800) begin
        v = (t % 5 == 0);
        r[20:19] = 2'd1;
      end else if (t >= 800 && t < 2000) begin
        v = (lfsr[31:30] == 2'b00);
      end else if (t >= 2000 && t < 2600) begin
        v = 1'b1;
      end
      arr_valid = v;
      {arr_id, arr_write, arr_bg, arr_bank, arr_row, arr_col} = r;
      model_step(v, r);
      @(negedge clk);
    end
    check({e_tag, " final"}, {cmd_o, out_id, out_write, out_bg, out_bank, out_row, out_col},
          {e_cmd, e_req});
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule